// File: doc/BRIEF.md
# I2C Byte-Completion Service Flag

This block keeps the pending-service flag of a multi-master I2C controller. The flag is high while the controller may keep clocking. At the end of every byte the flag drops, and this raises a single-cycle interrupt request. While the flag is low the block asks the clock generator to hold SCL low. The bus clock therefore stretches until software services the byte. The flag rises again when software writes the data register, when the controller is disabled or reset, or, in split-acknowledge operation, when software writes the second control register.

The block counts the strobes of the internal bit clock. The acknowledge-clock option selects whether a byte ends on its 8th clock or on its 9th clock. In slave receive with 7-bit addressing, the address byte ends service only on an address or general-call match. In free format, the address byte always ends service. An arbitration loss during transmit ends the byte at once. Shifting, address comparison and arbitration are done by neighbouring logic, and their results arrive here as strobes and levels. All control pins are plain levels or one-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `i2c_byte_flag`

## Requirements
- R1: After reset, `flag` is 1, `irq` is 0 and `scl_hold` is 0.
- R2: With `ack_clk_en`=0, `flag` falls on the 8th `bit_clk` strobe counted from `start_det` or from the end of the previous byte, and not on an earlier strobe.
- R3: With `ack_clk_en`=1, `flag` stays 1 through the 8th strobe and falls on the 9th strobe (the acknowledge clock).
- R4: While `flag` is 0, `scl_hold` is 1, and `bit_clk` strobes are ignored: they neither change `flag` nor advance the bit count.
- R5: A one-cycle `wr_data`, a cycle with `enable`=0, or a cycle with `soft_rst`=1 sets `flag` to 1 on the next clock edge, with no `irq`.
- R6: `wr_ctrl2` sets `flag` only when `wait_en`=1 and a split-acknowledge wait is pending. Otherwise it leaves `flag` unchanged.
- R7: With `rx_mode`=0, an `arb_lost` strobe clears `flag` on the next edge and restarts the bit count.
- R8: With `slave_mode`=1, `rx_mode`=1 and `free_fmt`=0, the first byte after `start_det` clears `flag` only if `addr_match` or `gcall_match` is 1 on its final strobe. Later bytes clear it unconditionally.
- R9: With `free_fmt`=1, the first byte after `start_det` clears `flag` at its final strobe without any match.
- R10: With `ack_clk_en`=1, `wait_en`=1 and `rx_mode`=1, `flag` falls on the 8th strobe and a wait becomes pending. After `wr_ctrl2` sets `flag`, it falls again on the 9th strobe, giving a second interrupt.
- R11: When a set cause and a clear cause coincide, `flag` ends at 1 and no `irq` is produced.
- R12: `irq` is high for exactly one cycle, in the same cycle that `flag` is first seen low after being high, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable level |
| soft_rst | input | 1 | Controller reset control level |
| bit_clk | input | 1 | One-cycle strobe per completed internal bit clock |
| ack_clk_en | input | 1 | 1: byte has a 9th (acknowledge) clock |
| wait_en | input | 1 | Enables the split-acknowledge wait |
| rx_mode | input | 1 | 1: receiving, 0: transmitting |
| slave_mode | input | 1 | 1: addressed as slave |
| free_fmt | input | 1 | 1: free data format, no address compare |
| start_det | input | 1 | START condition strobe; next byte is an address byte |
| addr_match | input | 1 | Own slave address matched |
| gcall_match | input | 1 | General-call address received |
| arb_lost | input | 1 | Arbitration-lost strobe |
| wr_data | input | 1 | Data register write strobe |
| wr_ctrl2 | input | 1 | Second control register write strobe |
| flag | output | 1 | Pending-service flag (0 = byte awaits service) |
| irq | output | 1 | One-cycle interrupt request on the flag's falling edge |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
Four properties are checked in every cycle. The flag rises after any set cause, even when a clear cause arrives in the same cycle. An interrupt appears exactly when the flag falls and lasts one cycle. A low flag stays low unless it is set. A control-register write without the wait option is ignored. Only the bench scenarios show where the flag falls in a byte: on the 8th or 9th strobe for each acknowledge option, on the address match or general call in addressed slave receive, on the double drop in split-acknowledge receive, and on the immediate drop at arbitration loss. They also show that strobes arriving while the flag is low are not counted.

// File: rtl/i2c_byte_flag_pkg.sv
package i2c_byte_flag_pkg;
  // Position events from the bit counter, valid for one cycle.
  typedef struct packed {
    logic last_data; // strobe that ends the data bits
    logic wrap;      // strobe that ends the whole byte
  } bitpos_t;
endpackage

// File: rtl/i2c_byte_flag_bitcnt.sv
module i2c_byte_flag_bitcnt
  import i2c_byte_flag_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart,
  input  logic    start_det,
  input  logic    step,
  input  logic    ack_clk_en,
  output bitpos_t pos,
  output logic    first_byte
);
  localparam int CW = $clog2(DATA_BITS + 1);

  logic [CW-1:0] cnt_q;
  logic          at_data, at_ack;

  assign at_data       = (cnt_q == CW'(DATA_BITS - 1));
  assign at_ack        = (cnt_q == CW'(DATA_BITS));
  assign pos.last_data = step & at_data;
  assign pos.wrap      = ack_clk_en ? (step & at_ack) : (step & at_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      first_byte <= 1'b0;
    end else if (restart) begin
      cnt_q      <= '0;
      first_byte <= 1'b0;
    end else if (start_det) begin
      cnt_q      <= '0;
      first_byte <= 1'b1;
    end else if (step) begin
      if (pos.wrap) begin
        cnt_q      <= '0;
        first_byte <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_flag_cause.sv
module i2c_byte_flag_cause
  import i2c_byte_flag_pkg::*;
(
  input  bitpos_t pos,
  input  logic    first_byte,
  input  logic    wait_pend,
  input  logic    enable,
  input  logic    soft_rst,
  input  logic    ack_clk_en,
  input  logic    wait_en,
  input  logic    rx_mode,
  input  logic    slave_mode,
  input  logic    free_fmt,
  input  logic    addr_match,
  input  logic    gcall_match,
  input  logic    arb_lost,
  input  logic    wr_data,
  input  logic    wr_ctrl2,
  output logic    set_req,
  output logic    clr_req,
  output logic    arm_wait,
  output logic    drop_wait
);
  logic addr_gate, byte_ok, split, ctrl2_ok;

  always_comb begin
    // Address byte in addressed slave receive needs a match to count.
    addr_gate = slave_mode & rx_mode & first_byte & ~free_fmt;
    byte_ok   = ~addr_gate | addr_match | gcall_match;
    split     = ack_clk_en & wait_en & rx_mode;
    ctrl2_ok  = wr_ctrl2 & wait_en & wait_pend;

    set_req   = wr_data | ~enable | soft_rst | ctrl2_ok;
    clr_req   = (byte_ok & (pos.wrap | (split & pos.last_data)))
              | (arb_lost & ~rx_mode);
    arm_wait  = split & pos.last_data & byte_ok;
    drop_wait = ctrl2_ok | pos.wrap | ~enable | soft_rst;
  end
endmodule

// File: rtl/i2c_byte_flag.sv
module i2c_byte_flag
  import i2c_byte_flag_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic soft_rst,
  input  logic bit_clk,
  input  logic ack_clk_en,
  input  logic wait_en,
  input  logic rx_mode,
  input  logic slave_mode,
  input  logic free_fmt,
  input  logic start_det,
  input  logic addr_match,
  input  logic gcall_match,
  input  logic arb_lost,
  input  logic wr_data,
  input  logic wr_ctrl2,
  output logic flag,
  output logic irq,
  output logic scl_hold
);
  bitpos_t pos;
  logic    first_byte, wait_pend_q, flag_q, flag_d, irq_q;
  logic    set_req, clr_req, arm_wait, drop_wait, step, restart;

  // Strobes only count while the bus is running (flag high).
  assign step    = bit_clk & flag_q & enable;
  assign restart = ~enable | soft_rst | (arb_lost & ~rx_mode);

  i2c_byte_flag_bitcnt #(.DATA_BITS(DATA_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .start_det(start_det),
    .step(step), .ack_clk_en(ack_clk_en), .pos(pos), .first_byte(first_byte)
  );

  i2c_byte_flag_cause u_cause (
    .pos(pos), .first_byte(first_byte), .wait_pend(wait_pend_q),
    .enable(enable), .soft_rst(soft_rst), .ack_clk_en(ack_clk_en),
    .wait_en(wait_en), .rx_mode(rx_mode), .slave_mode(slave_mode),
    .free_fmt(free_fmt), .addr_match(addr_match), .gcall_match(gcall_match),
    .arb_lost(arb_lost), .wr_data(wr_data), .wr_ctrl2(wr_ctrl2),
    .set_req(set_req), .clr_req(clr_req), .arm_wait(arm_wait),
    .drop_wait(drop_wait)
  );

  always_comb begin
    if (set_req)      flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q      <= 1'b1;
      irq_q       <= 1'b0;
      wait_pend_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_q & ~flag_d;
      if (drop_wait)     wait_pend_q <= 1'b0;
      else if (arm_wait) wait_pend_q <= 1'b1;
    end
  end

  assign flag     = flag_q;
  assign irq      = irq_q;
  assign scl_hold = ~flag_q;
endmodule

// File: rtl/i2c_byte_flag_chk.sv
module i2c_byte_flag_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic soft_rst,
  input logic wait_en,
  input logic wr_data,
  input logic wr_ctrl2,
  input logic flag,
  input logic irq
);
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data || soft_rst || !enable) |=> flag); // R11
  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $fell(flag)); // R12
  AST_FALL_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> irq); // R12
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R12
  AST_LOW_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && enable && !soft_rst && !wr_data && !wr_ctrl2) |=> !flag); // R4
  AST_CTRL2_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !wait_en && enable && !soft_rst && !wr_data) |=> !flag); // R6
  AST_DISABLED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq); // R5
endmodule

bind i2c_byte_flag i2c_byte_flag_chk u_chk (.*);

// File: tb/i2c_byte_flag_tb.sv
module i2c_byte_flag_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, soft_rst = 1'b0, bit_clk = 1'b0, ack_clk_en = 1'b0;
  logic wait_en = 1'b0, rx_mode = 1'b0, slave_mode = 1'b0, free_fmt = 1'b0;
  logic start_det = 1'b0, addr_match = 1'b0, gcall_match = 1'b0;
  logic arb_lost = 1'b0, wr_data = 1'b0, wr_ctrl2 = 1'b0;
  logic flag, irq, scl_hold;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string exp_q[$];

  always #5 clk = ~clk;

  i2c_byte_flag u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .bit_clk(bit_clk), .ack_clk_en(ack_clk_en), .wait_en(wait_en),
    .rx_mode(rx_mode), .slave_mode(slave_mode), .free_fmt(free_fmt),
    .start_det(start_det), .addr_match(addr_match), .gcall_match(gcall_match),
    .arb_lost(arb_lost), .wr_data(wr_data), .wr_ctrl2(wr_ctrl2),
    .flag(flag), .irq(irq), .scl_hold(scl_hold)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_clk = 1'b1; tick(); bit_clk = 1'b0; tick();
    end
  endtask

  task automatic expect_irq(input string req); exp_q.push_back(req); endtask
  task automatic p_data();  wr_data = 1'b1;   tick(); wr_data = 1'b0;   tick(); endtask
  task automatic p_ctrl2(); wr_ctrl2 = 1'b1;  tick(); wr_ctrl2 = 1'b0;  tick(); endtask
  task automatic p_start(); start_det = 1'b1; tick(); start_det = 1'b0; tick(); endtask
  task automatic p_arb();   arb_lost = 1'b1;  tick(); arb_lost = 1'b0; tick(); endtask

  // Monitor: every interrupt must match a queued expectation (R12).
  logic prev_irq = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R12: actual irq 1 expected 0 (unexpected) at %0t", $time);
        end else begin
          string tag;
          tag = exp_q.pop_front();
          chk({tag, " flag low with irq"}, flag, 1'b0);
        end
        if (prev_irq) begin
          fails++;
          $display("FAIL R12: actual irq width 2 expected 1 at %0t", $time);
        end
      end
      prev_irq <= irq;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 flag", flag, 1'b1); chk("R1 irq", irq, 1'b0); chk("R1 hold", scl_hold, 1'b0);
    rst_n = 1'b1; enable = 1'b1; tick();

    // R2: 8-clock byte
    p_start(); clocks(7); chk("R2 no early fall", flag, 1'b1);
    expect_irq("R2"); clocks(1); chk("R2 fall on 8th", flag, 1'b0);
    chk("R4 hold", scl_hold, 1'b1);

    // R4: strobes while low are ignored
    clocks(3); chk("R4 strobes ignored", flag, 1'b0);
    p_data(); chk("R5 data write sets", flag, 1'b1);
    clocks(7); chk("R4 count not advanced", flag, 1'b1);
    expect_irq("R2"); clocks(1); chk("R2 second byte", flag, 1'b0);

    // R3: 9-clock byte
    ack_clk_en = 1'b1; p_data();
    clocks(8); chk("R3 holds past 8th", flag, 1'b1);
    expect_irq("R3"); clocks(1); chk("R3 fall on 9th", flag, 1'b0);

    // R7: arbitration loss in transmit
    p_data(); clocks(3); expect_irq("R7"); p_arb(); chk("R7 arb lost clears", flag, 1'b0);

    // R5: disable and soft reset set the flag
    enable = 1'b0; tick(); enable = 1'b1; tick(); chk("R5 disable sets", flag, 1'b1);
    expect_irq("R7"); p_arb(); chk("R7 again", flag, 1'b0);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0; tick(); chk("R5 soft reset sets", flag, 1'b1);

    // R11: set and clear together
    clocks(8); wr_data = 1'b1; bit_clk = 1'b1; tick();
    wr_data = 1'b0; bit_clk = 1'b0; tick(); chk("R11 set wins", flag, 1'b1);

    // R6: ctrl2 write ignored without wait option
    expect_irq("R3"); clocks(9); chk("R3 fall", flag, 1'b0);
    p_ctrl2(); chk("R6 ctrl2 ignored", flag, 1'b0);
    p_data();

    // R10: split acknowledge in receive
    rx_mode = 1'b1; wait_en = 1'b1; p_start();
    clocks(7); chk("R10 before 8th", flag, 1'b1);
    expect_irq("R10"); clocks(1); chk("R10 fall on 8th", flag, 1'b0);
    p_ctrl2(); chk("R6 ctrl2 with wait sets", flag, 1'b1);
    expect_irq("R10"); clocks(1); chk("R10 fall on ack", flag, 1'b0);
    p_ctrl2(); chk("R6 ctrl2 no pending ignored", flag, 1'b0);
    p_data(); wait_en = 1'b0;

    // R8: addressed slave receive
    slave_mode = 1'b1; p_start(); clocks(9); chk("R8 no match keeps flag", flag, 1'b1);
    p_start(); clocks(8); addr_match = 1'b1; expect_irq("R8");
    clocks(1); addr_match = 1'b0; chk("R8 addr match clears", flag, 1'b0);
    p_data(); p_start(); clocks(8); gcall_match = 1'b1; expect_irq("R8");
    clocks(1); gcall_match = 1'b0; chk("R8 general call clears", flag, 1'b0);
    p_data(); expect_irq("R8"); clocks(9); chk("R8 data byte clears", flag, 1'b0);
    p_data();

    // R9: free format
    free_fmt = 1'b1; p_start(); expect_irq("R9"); clocks(9);
    chk("R9 free format clears", flag, 1'b0);
    p_data(); repeat (3) tick();

    chk("R12 all expected irqs seen", exp_q.size() == 0, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule